// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a single asynchronous serial input line and turns each character on it into a parallel byte. The line is brought into the clock domain through a short flip-flop chain, and a one-cycle enable at sixteen times the bit rate paces all timing. A falling edge is accepted as a start bit only when the line is still low half a bit later. Every later bit is sampled at the centre of its bit period.

The character format comes from static control inputs: five to eight data bits (sent least significant bit first), an optional parity bit with odd, even or fixed-level checking, and one stop bit. The receiver latches the format when it accepts a start bit. Once the stop bit has been sampled, the block gives the received byte right-aligned with zeros above the word, a one-cycle valid strobe, and three status flags in the same cycle: parity error, framing error and line break. A line held low through a whole character is reported as a break. After a break or a framing error the receiver waits for the line to go high before it looks for a new start bit.

Top module: `uart_rx_frame`

## Requirements
- R1: After reset, rx_valid_o, err_parity_o, err_frame_o, brk_det_o and rx_data_o are all 0. No character is reported until a valid frame has been received.
- R2: A low level on rx_line_i that has gone high again by the eighth tick after the falling edge is discarded. No valid strobe follows it.
- R3: Data bits arrive least significant bit first. The word length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 bits. The byte is right-aligned in rx_data_o and the bits above the word are 0.
- R4: rx_valid_o is high for exactly one clock cycle per character. The three status flags are valid only in that cycle and are 0 at all other times.
- R5: With parity on and par_even_i = 0, the bit after the last data bit is the parity bit. err_parity_o is set unless the data bits together with the parity bit hold an odd number of ones.
- R6: With parity on and par_even_i = 1 (stick off), err_parity_o is set unless the data bits together with the parity bit hold an even number of ones.
- R7: With parity on and par_stick_i = 1, the parity bit must equal the inverse of par_even_i, whatever the data. err_parity_o is set on a mismatch.
- R8: With parity off, the bit after the last data bit is the stop bit, and err_parity_o stays 0.
- R9: err_frame_o is set when the sampled stop bit is 0. The receiver then accepts no start bit until the line has been high.
- R10: Only one stop bit is examined. A new start bit may follow a single high stop bit directly, and both characters are received.
- R11: brk_det_o is set, together with err_frame_o, when every data bit, the parity bit (if enabled) and the stop bit sample as 0. The line must then return high before the next character can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16_i | input | 1 | One-cycle enable at 16x bit rate |
| rx_line_i | input | 1 | Asynchronous serial input, idle high |
| word_len_i | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity when 1, odd when 0 |
| par_stick_i | input | 1 | Parity bit fixed at inverse of par_even_i |
| rx_data_o | output | 8 | Received character, zero-filled above word |
| rx_valid_o | output | 1 | One-cycle strobe per character |
| err_parity_o | output | 1 | Parity mismatch, with rx_valid_o |
| err_frame_o | output | 1 | Stop bit sampled low, with rx_valid_o |
| brk_det_o | output | 1 | All-zero character, with rx_valid_o |

## Verification
The hardest case to reach from the ports is the re-arm after a zero stop bit. The line is still low once the character has been reported, so a careless receiver would take it as a fresh start bit. The stimulus holds the line low for many bit times after a break and then sends a normal character. It checks that exactly one strobe came from the long low stretch and that the following character decodes cleanly. A framing-error character whose data is not all zero is checked in the same way. The opposite timing, with a start bit directly after a single stop bit, is driven back to back to show that no second stop bit is required.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers for the serial character receiver.
// Assumes data words of at most 8 bits.
package uart_rx_pkg;

    // Latched character format
    typedef struct packed {
        logic [1:0] wlen;       // 0..3 -> 5..8 data bits
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // Mask of valid data bits for a word length code
    function automatic logic [7:0] wlen_mask(input logic [1:0] code);
        logic [7:0] m;
        m = 8'h1F;
        for (int i = 5; i < 8; i++)
            if (i < 5 + int'(code)) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Module: brings the asynchronous line into the clock domain.
// Assumes the line is idle high, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[s] <= 1'b1;
                else if (s == 0)
                    chain_q[s] <= async_i;
                else
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
// Module: frame sequencer. Validates the start bit at half a bit, samples
// data, parity and stop bits at mid-bit, and holds after a zero stop bit
// until the line is high again.
// Assumes tick_i is a one-cycle enable at OVS times the bit rate.
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  rx_cfg_t       cfg_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          par_o,
    output logic          stop_o,
    output rx_cfg_t       cfg_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);

    rx_state_t     st_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] shr_q;
    logic          par_q;
    logic          stop_q;
    logic          done_q;
    rx_cfg_t       cfg_q;
    logic [IW-1:0] last_idx;
    logic          at_mid;

    // Index of the final data bit for the latched word length
    assign last_idx = IW'(cfg_q.wlen) + IW'(4);
    // True on the tick that lands at the centre of a bit
    assign at_mid = tick_i && (cnt_q == CNT_LAST);

    // Main sequencer: state, tick counter, bit index and captured bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            shr_q  <= '0;
            par_q  <= 1'b0;
            stop_q <= 1'b1;
            done_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (tick_i && !rx_i) begin
                        st_q  <= ST_START;
                        cnt_q <= '0;
                    end
                end
                ST_START: begin
                    if (tick_i) begin
                        if (cnt_q == CNT_HALF) begin
                            cnt_q <= '0;
                            if (rx_i) begin
                                st_q <= ST_IDLE;
                            end else begin
                                st_q  <= ST_DATA;
                                idx_q <= '0;
                                shr_q <= '0;
                                par_q <= 1'b0;
                                cfg_q <= cfg_i;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick_i) cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                    if (at_mid) begin
                        shr_q[idx_q] <= rx_i;
                        if (idx_q == last_idx)
                            st_q <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (tick_i) cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                    if (at_mid) begin
                        par_q <= rx_i;
                        st_q  <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (tick_i) cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                    if (at_mid) begin
                        stop_q <= rx_i;
                        done_q <= 1'b1;
                        st_q   <= rx_i ? ST_IDLE : ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tick_i && rx_i) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign data_o = shr_q;
    assign par_o  = par_q;
    assign stop_o = stop_q;
    assign cfg_o  = cfg_q;

    // A start bit that is high again at half a bit goes back to idle
    p_start_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_START && tick_i && cnt_q == CNT_HALF && rx_i) |=> st_q == ST_IDLE);

    // A zero stop bit leads to the hold state, not to idle
    p_rearm_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !stop_q) |-> st_q == ST_HOLD);

    // The hold state persists while the line stays low
    p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !rx_i) |=> st_q == ST_HOLD);

    // A high stop bit lets the receiver re-arm at once
    p_one_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && stop_q) |-> st_q == ST_IDLE);
endmodule

// File: rtl/uart_rx_check.sv
// Module: parity and break evaluation for one completed character.
// Assumes unused upper data bits arrive already zero.
module uart_rx_check
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic          par_i,
    input  logic          stop_i,
    input  rx_cfg_t       cfg_i,
    output logic          par_err_o,
    output logic          brk_o
);
    logic ones_odd;
    logic par_exp;

    // Expected parity bit for the latched parity mode
    always_comb begin
        ones_odd = ^data_i;
        if (cfg_i.par_stick)
            par_exp = ~cfg_i.par_even;
        else if (cfg_i.par_even)
            par_exp = ones_odd;
        else
            par_exp = ~ones_odd;
    end

    // Mismatch and all-zero character detection
    always_comb begin
        par_err_o = cfg_i.par_en && (par_i != par_exp);
        brk_o     = (data_i == '0) && !stop_i && (!cfg_i.par_en || !par_i);
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Module: top of the serial character receiver. Synchronizes the line,
// runs the frame sequencer and registers data and status for one cycle.
// Assumes the format inputs are steady around each start bit.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16_i,
    input  logic       rx_line_i,
    input  logic [1:0] word_len_i,
    input  logic       par_en_i,
    input  logic       par_even_i,
    input  logic       par_stick_i,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       err_parity_o,
    output logic       err_frame_o,
    output logic       brk_det_o
);
    localparam int DW = 8;

    logic          rx_s;
    rx_cfg_t       cfg_in;
    rx_cfg_t       cfg_lat;
    logic          done;
    logic [DW-1:0] fr_data;
    logic          fr_par;
    logic          fr_stop;
    logic          par_err;
    logic          brk;

    assign cfg_in = '{wlen: word_len_i, par_en: par_en_i,
                      par_even: par_even_i, par_stick: par_stick_i};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rx_line_i), .sync_o(rx_s)
    );

    uart_rx_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rx_i(rx_s),
        .cfg_i(cfg_in), .done_o(done), .data_o(fr_data), .par_o(fr_par),
        .stop_o(fr_stop), .cfg_o(cfg_lat)
    );

    uart_rx_check #(.DW(DW)) u_chk (
        .data_i(fr_data), .par_i(fr_par), .stop_i(fr_stop), .cfg_i(cfg_lat),
        .par_err_o(par_err), .brk_o(brk)
    );

    // Output register: strobe plus flags for one cycle, data held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o    <= '0;
            rx_valid_o   <= 1'b0;
            err_parity_o <= 1'b0;
            err_frame_o  <= 1'b0;
            brk_det_o    <= 1'b0;
        end else begin
            rx_valid_o   <= done;
            err_parity_o <= done && par_err;
            err_frame_o  <= done && !fr_stop;
            brk_det_o    <= done && brk;
            if (done) rx_data_o <= fr_data;
        end
    end

    // Strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // Flags only appear with the strobe
    p_flags_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity_o || err_frame_o || brk_det_o) |-> rx_valid_o);

    // Bits above the word are zero
    p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (rx_data_o & ~wlen_mask(cfg_lat.wlen)) == 8'h00);

    // Break is always a framing error with empty data
    p_brk_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det_o |-> (err_frame_o && rx_data_o == 8'h00));

    // No parity error while parity is off
    p_par_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !cfg_lat.par_en) |-> !err_parity_o);
endmodule

// File: tb/uart_rx_frame_bench.sv
module uart_rx_frame_bench;
    localparam int BIT_CLKS = 64;   // 16 ticks, one tick per 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       line = 1'b1;
    logic [1:0] wl = 2'd3;
    logic       pe = 1'b0, eps = 1'b0, sp = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_valid_o, err_parity_o, err_frame_o, brk_det_o;

    int tests = 0, fails = 0, cyc = 0;
    int cap_n = 0;
    logic [7:0] cap_data, prev_data;
    logic cap_pe, cap_fe, cap_bk;

    always #4 clk = ~clk;

    uart_rx_frame u_uart_rx_frame (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rx_line_i(line),
        .word_len_i(wl), .par_en_i(pe), .par_even_i(eps), .par_stick_i(sp),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
        .brk_det_o(brk_det_o)
    );

    // Tick generator: one-cycle enable every fourth clock
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            tick = (k % 4 == 0);
        end
    end

    // Capture each strobe away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rx_valid_o) begin
            prev_data = cap_data;
            cap_data = rx_data_o; cap_pe = err_parity_o;
            cap_fe = err_frame_o; cap_bk = brk_det_o;
            cap_n++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(logic v, int n);
        line = v;
        repeat (n) @(negedge clk);
    endtask

    // One character: start, data LSB first, optional parity, one stop bit
    task automatic send(logic [7:0] d, logic [1:0] w, logic p, logic e,
                        logic s, logic bad, logic stopv);
        logic pb;
        logic [7:0] m;
        m  = 8'h1F >> 0;
        for (int i = 5; i < 5 + int'(w); i++) m[i] = 1'b1;
        pb = s ? ~e : (e ? ^(d & m) : ~^(d & m));
        pb = pb ^ bad;
        wl = w; pe = p; eps = e; sp = s;
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 5 + int'(w); i++) hold(d[i], BIT_CLKS);
        if (p) hold(pb, BIT_CLKS);
        hold(stopv, BIT_CLKS);
    endtask

    // {data, wlen, par_en, even, stick, bad_parity, stop}
    localparam int NV = 14;
    localparam logic [14:0] VEC [0:NV-1] = '{
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h3C, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h3C, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h55, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h55, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'h81, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h81, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h81, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h00, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h00, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h6B, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        int n0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 valid", rx_valid_o, 0);
        check("R1 data", rx_data_o, 0);
        check("R1 flags", {err_parity_o, err_frame_o, brk_det_o}, 0);
        rst_n = 1'b1;
        hold(1'b1, 3 * BIT_CLKS);
        check("R1 no strobe", cap_n, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] d, m, ed;
            logic [1:0] w;
            logic p, e, s, bad, st, pb, ebk;
            {d, w, p, e, s, bad, st} = VEC[i];
            m = 8'h1F;
            for (int b = 5; b < 5 + int'(w); b++) m[b] = 1'b1;
            ed = d & m;
            pb = (s ? ~e : (e ? ^ed : ~^ed)) ^ bad;
            ebk = (ed == 0) && !st && (!p || !pb);
            n0 = cap_n;
            send(d, w, p, e, s, bad, st);
            hold(1'b1, 2 * BIT_CLKS);
            check("R4 one strobe", cap_n - n0, 1);
            check("R3 data", cap_data, ed);
            check("R5 R6 R7 R8 parity", cap_pe, p && bad);
            check("R9 frame", cap_fe, !st);
            check("R11 break", cap_bk, ebk);
        end

        // R2: short low pulse is discarded
        n0 = cap_n;
        hold(1'b0, 12);
        hold(1'b1, 3 * BIT_CLKS);
        check("R2 glitch", cap_n - n0, 0);

        // R10: back-to-back characters with a single stop bit
        n0 = cap_n;
        send(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h3E, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        hold(1'b1, 2 * BIT_CLKS);
        check("R10 count", cap_n - n0, 2);
        check("R10 first", prev_data, 8'hC3);
        check("R10 second", cap_data, 8'h3E);
        check("R10 clean", {cap_pe, cap_fe}, 0);

        // R11: long break gives one strobe, then clean recovery
        n0 = cap_n;
        wl = 2'd3; pe = 1'b0;
        hold(1'b0, 12 * BIT_CLKS);
        hold(1'b1, 2 * BIT_CLKS);
        check("R11 long break strobes", cap_n - n0, 1);
        check("R11 long break flag", {cap_bk, cap_fe}, 2'b11);
        send(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        hold(1'b1, 2 * BIT_CLKS);
        check("R11 recovery count", cap_n - n0, 2);
        check("R11 recovery data", cap_data, 8'h96);
        check("R11 recovery flags", {cap_pe, cap_fe, cap_bk}, 0);

        // R9: framing error with nonzero data, line low a while after
        n0 = cap_n;
        send(8'h7E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hold(1'b0, 3 * BIT_CLKS);
        hold(1'b1, 2 * BIT_CLKS);
        check("R9 single strobe", cap_n - n0, 1);
        check("R9 no break", {cap_fe, cap_bk}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        tests++; fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule